// File: doc/BRIEF.md
# S/PDIF Transmit User-Bit Double Buffer

This block holds the user bits that an S/PDIF transmitter sends in its subframes. It has two equal byte-wide buffers. At any time, one buffer is the *send* buffer and the other is the *fill* buffer. The transmitter reads the send buffer one bit per subframe. The host writes the fill buffer one byte at a time. To do so it first loads a byte index into an indirect address register, then writes the byte through a data register. When the fill buffer is complete, the host issues a commit. At the next block boundary the two buffers swap roles, and a sticky "ready" flag tells the host that the other buffer may now be rewritten. If there is no commit by that boundary, the send buffer is transmitted again.

The transmitter drives a subframe strobe when it consumes a user bit. Together with that strobe it signals whether the *next* subframe carries the block-start preamble. A configuration input sets the block length to either 384 bits (bytes 0..47) or 768 bits (bytes 0..95). Biphase coding and preamble generation stay in the transmitter.

Two state machines control the block:
- **Sequencer** (`SEQ_IDLE`, `SEQ_RUN`):
  - `SEQ_IDLE` goes to `SEQ_RUN` on a strobe that flags the next subframe as a block start. That transition is itself a block boundary.
  - In `SEQ_RUN` the bit pointer has three transitions on a strobe: *advance*, *wrap* at the last bit of the selected length, and *realign* on an unexpected block start.
- **Fill-buffer control** (`FILL_OPEN`, `FILL_LOCKED`):
  - *commit* moves `FILL_OPEN` to `FILL_LOCKED`.
  - *swap* at a block boundary moves `FILL_LOCKED` back to `FILL_OPEN`.

Top module: `spdif_ub_dbuf`

## Requirements
- R1: After reset, `ub_bit`, `sts_ready` and `irq` are 0.
- R2: In `SEQ_IDLE`, `ub_bit` is 0. A strobe with `sf_nxt_z` = 1 starts the first block, and that strobe consumes a 0.
- R3: Bits are sent from byte index 0 upward, bit 0 of each byte first. Each bit appears on `ub_bit` in the cycle after the previous strobe and holds until the strobe that consumes it.
- R4: With `cfg_long` = 0, a block is 384 bits (bytes 0..47) and the pointer wraps to 0 after bit 383. With `cfg_long` = 1, a block is 768 bits (bytes 0..95). In that mode, a block-start flag on the strobe of bit 383 is the expected mid-buffer start and does not restart the pointer.
- R5: The buffers swap only at a block boundary when a commit is pending. At a boundary with no pending commit, the same buffer is sent again.
- R6: A data-register write stores `host_wdata` in the fill buffer at the byte index last loaded into the address register. It does not change the buffer being sent.
- R7: Data-register writes made after a commit and before the swap are ignored.
- R8: `sts_ready` is set by a swap and stays set until `sts_rd` is pulsed. A swap in the same cycle as `sts_rd` leaves it set.
- R9: `irq` is high exactly when `sts_ready` and `irq_mask` are both high.
- R10: In `SEQ_RUN`, a strobe with `sf_nxt_z` = 1 at any pointer value other than the last bit, or other than bit 383 in long mode, is a block boundary. It resets the pointer to 0, so the next bit sent is bit 0 of byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long | input | 1 | Block length select: 0 = 384 bits, 1 = 768 bits |
| host_addr_we | input | 1 | Load `host_wdata` into the indirect address register |
| host_data_we | input | 1 | Write `host_wdata` to the addressed fill-buffer byte |
| host_wdata | input | 8 | Host write data for both registers |
| host_commit | input | 1 | Mark the fill buffer complete |
| sts_rd | input | 1 | Status read strobe; clears `sts_ready` |
| irq_mask | input | 1 | Interrupt enable for `sts_ready` |
| sf_strobe | input | 1 | Transmitter consumes the presented user bit |
| sf_nxt_z | input | 1 | With `sf_strobe`: the next subframe starts a block |
| ub_bit | output | 1 | User bit for the upcoming subframe |
| sts_ready | output | 1 | Sticky flag: fill buffer may be rewritten |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check these rules on every cycle:
- `ub_bit` stays 0 while idle.
- The send/fill selection changes only on a strobe while a commit is pending, and every swap resets the pointer.
- The pointer moves only on strobes.
- The sticky flag obeys its set, clear and hold rules, and the interrupt follows the flag and its mask.

Only the bench scenarios can show the contents of the stream:
- bit order within and across bytes;
- wrap length in both modes, including the ignored mid-buffer block start;
- repetition of a block when no commit has arrived;
- realignment on an early block start;
- that writes after a commit, and writes to the fill buffer, leave the transmitted bits untouched.

// File: rtl/spdif_ub_pkg.sv
package spdif_ub_pkg;

    // Bit sequencer: waiting for the first block start, or streaming
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Host side of the fill buffer: writable, or committed and waiting for a swap
    typedef enum logic [0:0] {
        FILL_OPEN   = 1'b0,
        FILL_LOCKED = 1'b1
    } fill_state_t;

endpackage

// File: rtl/ub_host_port.sv
module ub_host_port
    import spdif_ub_pkg::*;
#(
    parameter int MAX_BYTES = 96,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              commit,
    input  logic              swap,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_byte,
    output logic              commit_pend
);

    fill_state_t       fill_q, fill_d;
    logic [ADDR_W-1:0] addr_q;

    // Indirect address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_we) begin
            addr_q <= wdata;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= FILL_OPEN;
        end else begin
            fill_q <= fill_d;
        end
    end

    // Next state
    always_comb begin
        fill_d = fill_q;
        unique case (fill_q)
            FILL_OPEN:   if (commit) fill_d = FILL_LOCKED;
            FILL_LOCKED: if (swap)   fill_d = FILL_OPEN;
            default:     fill_d = FILL_OPEN;
        endcase
    end

    // Outputs: byte writes are accepted only while the fill buffer is open
    always_comb begin
        commit_pend = (fill_q == FILL_LOCKED);
        wr_en       = data_we && (fill_q == FILL_OPEN) && (int'(addr_q) < MAX_BYTES);
        wr_idx      = addr_q[IDX_W-1:0];
        wr_byte     = wdata[7:0];
    end

endmodule

// File: rtl/ub_seq.sv
module ub_seq
    import spdif_ub_pkg::*;
#(
    parameter int BLOCK_BITS = 384,
    parameter int MAX_BITS   = 768,
    parameter int PTR_W      = $clog2(MAX_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_long,
    input  logic             sf_strobe,
    input  logic             sf_nxt_z,
    input  logic             commit_pend,
    output logic [PTR_W-1:0] ptr,
    output logic             tx_sel,
    output logic             swap,
    output logic             run
);

    localparam logic [PTR_W-1:0] SHORT_LAST = PTR_W'(BLOCK_BITS - 1);
    localparam logic [PTR_W-1:0] LONG_LAST  = PTR_W'(MAX_BITS - 1);

    seq_state_t       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             sel_q, sel_d;
    logic [PTR_W-1:0] len_last;
    logic             at_last;
    logic             mid_start;
    logic             boundary;

    // Boundary decode
    always_comb begin
        len_last  = cfg_long ? LONG_LAST : SHORT_LAST;
        at_last   = (ptr_q == len_last);
        mid_start = cfg_long && (ptr_q == SHORT_LAST);
        boundary  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: boundary = sf_strobe && sf_nxt_z;
            SEQ_RUN:  boundary = sf_strobe && (at_last || (sf_nxt_z && !mid_start));
            default:  boundary = 1'b0;
        endcase
        swap = boundary && commit_pend;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (sf_strobe && sf_nxt_z) state_d = SEQ_RUN;
            SEQ_RUN:  state_d = SEQ_RUN;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs: pointer (advance, wrap, realign) and buffer selection
    always_comb begin
        ptr_d = ptr_q;
        sel_d = sel_q;
        if (boundary) begin
            ptr_d = '0;
        end else if (sf_strobe && (state_q == SEQ_RUN)) begin
            ptr_d = ptr_q + 1'b1;
        end
        if (swap) begin
            sel_d = ~sel_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sel_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            sel_q <= sel_d;
        end
    end

    assign ptr    = ptr_q;
    assign tx_sel = sel_q;
    assign run    = (state_q == SEQ_RUN);

endmodule

// File: rtl/ub_store.sv
module ub_store #(
    parameter int MAX_BYTES = 96,
    parameter int IDX_W     = $clog2(MAX_BYTES),
    parameter int PTR_W     = $clog2(MAX_BYTES * 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic             tx_sel,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             run,
    output logic             ub_bit
);

    localparam int NBANK = 2;

    logic [PTR_W-4:0] byte_idx;
    logic [2:0]       bit_idx;
    logic [NBANK-1:0] bank_bit;
    logic             fill_sel;
    logic             bit_q;

    assign byte_idx = rd_ptr[PTR_W-1:3];
    assign bit_idx  = rd_ptr[2:0];
    assign fill_sel = ~tx_sel;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [7:0] mem [MAX_BYTES];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < MAX_BYTES; i++) begin
                    mem[i] <= '0;
                end
            end else if (wr_en && (fill_sel == 1'(b))) begin
                mem[wr_idx] <= wr_byte;
            end
        end

        assign bank_bit[b] = mem[byte_idx][bit_idx];
    end

    // Presented bit: registered read of the send buffer, 0 while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= run ? bank_bit[tx_sel] : 1'b0;
        end
    end

    assign ub_bit = bit_q;

endmodule

// File: rtl/ub_flag.sv
module ub_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    input  logic sts_rd,
    input  logic irq_mask,
    output logic sts_ready,
    output logic irq
);

    logic flag_q;

    // Set has priority over the clear-on-read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (swap) begin
            flag_q <= 1'b1;
        end else if (sts_rd) begin
            flag_q <= 1'b0;
        end
    end

    assign sts_ready = flag_q;
    assign irq       = flag_q & irq_mask;

endmodule

// File: rtl/spdif_ub_dbuf.sv
module spdif_ub_dbuf #(
    parameter int MAX_BYTES  = 96,
    parameter int BLOCK_BITS = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_long,
    input  logic       host_addr_we,
    input  logic       host_data_we,
    input  logic [7:0] host_wdata,
    input  logic       host_commit,
    input  logic       sts_rd,
    input  logic       irq_mask,
    input  logic       sf_strobe,
    input  logic       sf_nxt_z,
    output logic       ub_bit,
    output logic       sts_ready,
    output logic       irq
);

    localparam int MAX_BITS = MAX_BYTES * 8;
    localparam int PTR_W    = $clog2(MAX_BITS);
    localparam int IDX_W    = $clog2(MAX_BYTES);
    localparam int ADDR_W   = 8;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_byte;
    logic             commit_pend;
    logic             swap;
    logic             tx_sel;
    logic             run;
    logic [PTR_W-1:0] ptr;

    ub_host_port #(
        .MAX_BYTES (MAX_BYTES),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) host_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_we     (host_addr_we),
        .data_we     (host_data_we),
        .wdata       (host_wdata),
        .commit      (host_commit),
        .swap        (swap),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_byte     (wr_byte),
        .commit_pend (commit_pend)
    );

    ub_seq #(
        .BLOCK_BITS (BLOCK_BITS),
        .MAX_BITS   (MAX_BITS),
        .PTR_W      (PTR_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_long    (cfg_long),
        .sf_strobe   (sf_strobe),
        .sf_nxt_z    (sf_nxt_z),
        .commit_pend (commit_pend),
        .ptr         (ptr),
        .tx_sel      (tx_sel),
        .swap        (swap),
        .run         (run)
    );

    ub_store #(
        .MAX_BYTES (MAX_BYTES),
        .IDX_W     (IDX_W),
        .PTR_W     (PTR_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .tx_sel  (tx_sel),
        .rd_ptr  (ptr),
        .run     (run),
        .ub_bit  (ub_bit)
    );

    ub_flag flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (swap),
        .sts_rd    (sts_rd),
        .irq_mask  (irq_mask),
        .sts_ready (sts_ready),
        .irq       (irq)
    );

endmodule

// File: rtl/spdif_ub_dbuf_chk.sv
module spdif_ub_dbuf_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sf_strobe,
    input logic             sts_rd,
    input logic             irq_mask,
    input logic             ub_bit,
    input logic             sts_ready,
    input logic             irq,
    input logic             swap,
    input logic             commit_pend,
    input logic             tx_sel,
    input logic             run,
    input logic [PTR_W-1:0] ptr
);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ub_bit);

    // R5
    sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_sel) |-> $past(sf_strobe && commit_pend));

    // R5
    swap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (ptr == '0));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_strobe |=> $stable(ptr));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> sts_ready);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !swap) |=> !sts_ready);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_rd && !swap) |=> $stable(sts_ready));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_ready && irq_mask));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ready && irq_mask) |-> irq);

endmodule

bind spdif_ub_dbuf spdif_ub_dbuf_chk #(.PTR_W(PTR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sf_strobe   (sf_strobe),
    .sts_rd      (sts_rd),
    .irq_mask    (irq_mask),
    .ub_bit      (ub_bit),
    .sts_ready   (sts_ready),
    .irq         (irq),
    .swap        (swap),
    .commit_pend (commit_pend),
    .tx_sel      (tx_sel),
    .run         (run),
    .ptr         (ptr)
);

// File: tb/spdif_ub_dbuf_tb_top.sv
`timescale 1ns/100ps
module spdif_ub_dbuf_tb_top;

    localparam int MAX_BYTES = 96;
    localparam int WATCHDOG  = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_long = 1'b0;
    logic       host_addr_we = 1'b0;
    logic       host_data_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_commit = 1'b0;
    logic       sts_rd = 1'b0;
    logic       irq_mask = 1'b0;
    logic       sf_strobe = 1'b0;
    logic       sf_nxt_z = 1'b0;
    logic       ub_bit;
    logic       sts_ready;
    logic       irq;

    always #2.5 clk = ~clk;

    spdif_ub_dbuf dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_long     (cfg_long),
        .host_addr_we (host_addr_we),
        .host_data_we (host_data_we),
        .host_wdata   (host_wdata),
        .host_commit  (host_commit),
        .sts_rd       (sts_rd),
        .irq_mask     (irq_mask),
        .sf_strobe    (sf_strobe),
        .sf_nxt_z     (sf_nxt_z),
        .ub_bit       (ub_bit),
        .sts_ready    (sts_ready),
        .irq          (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    bit    exp_q[$];
    string tag_q[$];
    logic [7:0] img [3][MAX_BYTES];

    task automatic check_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: each consumed bit is compared with the scoreboard
    always @(negedge clk) begin
        bit    e;
        string t;
        if (rst_n && sf_strobe) begin
            if (exp_q.size() == 0) begin
                check_eq("R3", "strobe with empty scoreboard", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, "ub_bit", int'(ub_bit), int'(e));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic host_byte(int a, logic [7:0] d);
        tick(); host_addr_we = 1'b1; host_wdata = 8'(a);
        tick(); host_addr_we = 1'b0; host_data_we = 1'b1; host_wdata = d;
        tick(); host_data_we = 1'b0;
    endtask

    task automatic write_image(int k, int n);
        for (int i = 0; i < n; i++) host_byte(i, img[k][i]);
    endtask

    task automatic do_commit();
        tick(); host_commit = 1'b1;
        tick(); host_commit = 1'b0;
    endtask

    // Driver: pushes the expected bit, then strobes
    task automatic strobe(bit z, bit e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick(); sf_strobe = 1'b1; sf_nxt_z = z;
        tick(); sf_strobe = 1'b0; sf_nxt_z = 1'b0;
        tick();
        tick();
    endtask

    task automatic run_block(int k, int nbits, int commit_at, string tag);
        for (int i = 0; i < nbits; i++) begin
            bit z;
            if (i == commit_at) begin
                do_commit();
                host_byte(5, 8'h5A);   // after commit: must be ignored (R7)
            end
            z = (i == nbits - 1) || (nbits == 768 && i == 383);
            strobe(z, img[k][i / 8][i % 8], tag);
        end
    endtask

    task automatic check_flags(string tag, int exp_rdy, int exp_irq);
        @(negedge clk);
        check_eq(tag, "sts_ready", int'(sts_ready), exp_rdy);
        check_eq(tag, "irq", int'(irq), exp_irq);
    endtask

    initial begin
        #(WATCHDOG * 5.0);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            img[0][i] = 8'(i * 37 + 11);
            img[1][i] = 8'(i * 53 + 200);
            img[2][i] = 8'(i * 29 + 7) ^ 8'h3C;
        end

        repeat (4) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "ub_bit", int'(ub_bit), 0);
        check_eq("R1", "sts_ready", int'(sts_ready), 0);
        check_eq("R1", "irq", int'(irq), 0);

        // R2: idle strobes without block start give zero bits
        for (int i = 0; i < 3; i++) strobe(1'b0, 1'b0, "R2");

        write_image(0, 48);
        do_commit();
        host_byte(5, 8'h5A);            // R7: ignored, image 0 byte 5 kept
        strobe(1'b1, 1'b0, "R2");       // first block start, swap to image 0

        // R8 / R9: flag set, mask, clear on read
        check_flags("R8 R9", 1, 0);
        tick(); irq_mask = 1'b1;
        check_flags("R9", 1, 1);
        tick(); sts_rd = 1'b1;
        tick(); sts_rd = 1'b0;
        check_flags("R8", 0, 0);

        // R6: fill buffer writes do not disturb the stream
        write_image(1, 48);
        run_block(0, 384, -1, "R3 R4 R6 R7");
        check_flags("R5", 0, 0);

        // R5: no commit at the last boundary, same block repeats; commit mid-block
        run_block(0, 384, 200, "R5");
        check_flags("R8", 1, 1);

        // R10: early block start realigns to bit 0
        for (int i = 0; i < 100; i++) strobe(i == 99, img[1][i / 8][i % 8], "R10");
        write_image(2, 96);
        run_block(1, 384, 0, "R10 R7");

        // R4: long mode, mid-buffer block start keeps counting
        tick(); cfg_long = 1'b1;
        run_block(2, 768, -1, "R4");

        check_eq("R3", "scoreboard left over", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule